// File: doc/BRIEF.md
# Half-Bridge Dead-Time and Pulse-Width Guard

This block sits between a PWM source and the gate drivers of one half-bridge leg. It receives a separate on/off command for the upper switch and for the lower switch, and it drives one gate-enable output for each. A single state machine (both-off, upper-on, lower-on and blanking states) makes sure the two switches never conduct together. It holds both gates low for a counted blanking interval before any switch is enabled. It treats a simultaneous request for both switches as improper and keeps both gates off. It also discards command pulses shorter than a programmable minimum width.

Turn-on is the only delayed edge. A gate drops in the same cycle its command goes away. A one-cycle flag marks each new illegal both-on request. A second one-cycle flag marks each command pulse that the width filter discarded. Both delays come from 8-bit configuration inputs, and a value of zero disables the delay it controls.

Top module: `leg_guard`

## Requirements
- R1: `gate_hi` and `gate_lo` are never high in the same cycle.
- R2: A command rises while the other command is low and its own gate is off. With minimum width M and dead time D, counting the first clock edge that samples the command high as edge 1, the gate is low after edges 1 to M+D and high after edge M+D+1.
- R3: A gate output goes low in the same cycle that its command goes low, without waiting for a clock edge.
- R4: While both commands are high, both gates are low. `fault_both` is high for exactly one cycle, the cycle after the first cycle in which both commands are high.
- R5: A command pulse held high for P edges, with 1 <= P < M, never drives its gate high. `drop_narrow` is high for exactly one cycle, the cycle after the one in which the command fell.
- R6: A command pulse held for P >= M edges does not raise `drop_narrow`.
- R7: D = 0 removes blanking (turn-on after M+1 edges). M = 0 removes filtering (turn-on after D+1 edges).
- R8: `dead_cfg` is sampled when a blanking interval starts. `minw_cfg` is sampled while the command is idle. A change during a running interval or a pulse does not alter its timing.
- R9: After reset both gates and both flags are low, and the block sits in the both-off state.
- R10: When the upper command falls and the lower command rises in the same cycle, `gate_hi` drops at once. `gate_lo` follows the timing of R2, counted from that change, and both gates stay low in between.
- R11: If the requested command is withdrawn during blanking, that gate never turns on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_hi | input | 1 | Upper switch on request |
| cmd_lo | input | 1 | Lower switch on request |
| dead_cfg | input | 8 | Blanking length in clock cycles (0 = none) |
| minw_cfg | input | 8 | Minimum accepted pulse width in cycles (0 = no filter) |
| gate_hi | output | 1 | Upper switch gate enable |
| gate_lo | output | 1 | Lower switch gate enable |
| fault_both | output | 1 | One-cycle pulse on a new both-on request |
| drop_narrow | output | 1 | One-cycle pulse when a narrow pulse is discarded |

## Verification
The bench uses the default 8-bit configuration width but drives only small values: dead time and minimum width each from 0 to 3, on both channels. This makes every turn-on latency, including the zero-disable corners, checkable edge by edge against M+D+1. Narrow pulses of every width below minimum widths of 2 to 4 are swept, along with pulses of exactly the minimum width. With these small settings, configuration changes in the middle of an interval, withdrawal during blanking, swaps from one switch to the other, and illegal overlaps all finish within a few cycles, so each case is covered in full.

// File: rtl/leg_guard_pkg.sv
package leg_guard_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_HI    = 2'd1,
    ST_LO    = 2'd2,
    ST_BLANK = 2'd3
  } leg_state_e;

  localparam int unsigned CFG_W = 8;
endpackage

// File: rtl/leg_guard_rstsync.sv
module leg_guard_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/leg_guard_filter.sv
module leg_guard_filter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd,
  input  logic [W-1:0] minw_cfg,
  output logic         qual,
  output logic         drop
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] lat_q;
  logic [W-1:0] eff_w;
  logic         idle;
  logic         lat_en;
  logic         drop_q, drop_d;

  assign idle   = (cnt_q == '0);
  assign lat_en = idle;
  // width limit: fresh value while idle, frozen once a pulse is counting
  assign eff_w  = idle ? minw_cfg : lat_q;
  assign qual   = cmd && (cnt_q >= eff_w);

  always_comb begin
    if (!cmd)                 cnt_d = '0;
    else if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    else                      cnt_d = cnt_q;
    drop_d = !cmd && !idle && (cnt_q < lat_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      drop_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      drop_q <= drop_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_q <= '0;
    else if (lat_en) lat_q <= minw_cfg;
  end

  assign drop = drop_q;
endmodule

// File: rtl/leg_guard_fsm.sv
module leg_guard_fsm
  import leg_guard_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         want_hi,
  input  logic         want_lo,
  input  logic [W-1:0] dead_cfg,
  output leg_state_e   state
);
  leg_state_e   state_q, state_d;
  logic         tgt_q, tgt_d;      // 0 = upper, 1 = lower
  logic [W-1:0] dcnt_q, dcnt_d;
  logic         tgt_want, oth_want;

  assign tgt_want = tgt_q ? want_lo : want_hi;
  assign oth_want = tgt_q ? want_hi : want_lo;

  always_comb begin
    state_d = state_q;
    tgt_d   = tgt_q;
    dcnt_d  = dcnt_q;
    unique case (state_q)
      ST_OFF: begin
        if (want_hi || want_lo) begin
          if (dead_cfg == '0) state_d = want_lo ? ST_LO : ST_HI;
          else begin
            state_d = ST_BLANK;
            tgt_d   = want_lo;
            dcnt_d  = dead_cfg;
          end
        end
      end
      ST_HI: begin
        if (!want_hi) begin
          if (!want_lo)             state_d = ST_OFF;
          else if (dead_cfg == '0)  state_d = ST_LO;
          else begin
            state_d = ST_BLANK;
            tgt_d   = 1'b1;
            dcnt_d  = dead_cfg;
          end
        end
      end
      ST_LO: begin
        if (!want_lo) begin
          if (!want_hi)             state_d = ST_OFF;
          else if (dead_cfg == '0)  state_d = ST_HI;
          else begin
            state_d = ST_BLANK;
            tgt_d   = 1'b0;
            dcnt_d  = dead_cfg;
          end
        end
      end
      ST_BLANK: begin
        if (tgt_want) begin
          if (dcnt_q <= 1) state_d = tgt_q ? ST_LO : ST_HI;
          else             dcnt_d  = dcnt_q - 1'b1;
        end else if (oth_want) begin
          if (dead_cfg == '0) state_d = tgt_q ? ST_HI : ST_LO;
          else begin
            tgt_d  = !tgt_q;
            dcnt_d = dead_cfg;
          end
        end else begin
          state_d = ST_OFF;
        end
      end
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      tgt_q   <= 1'b0;
      dcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      tgt_q   <= tgt_d;
      dcnt_q  <= dcnt_d;
    end
  end

  assign state = state_q;
endmodule

// File: rtl/leg_guard.sv
module leg_guard
  import leg_guard_pkg::*;
#(
  parameter int unsigned W = CFG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_hi,
  input  logic         cmd_lo,
  input  logic [W-1:0] dead_cfg,
  input  logic [W-1:0] minw_cfg,
  output logic         gate_hi,
  output logic         gate_lo,
  output logic         fault_both,
  output logic         drop_narrow
);
  localparam int unsigned NCH = 2;

  logic             rst_i_n;
  logic [NCH-1:0]   cmd_v, qual_v, drop_v;
  logic             want_hi, want_lo;
  logic             both_on, both_q, fault_q;
  leg_state_e       state;

  leg_guard_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  assign cmd_v = {cmd_lo, cmd_hi};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    leg_guard_filter #(.W(W)) u_filt (
      .clk(clk), .rst_n(rst_i_n), .cmd(cmd_v[g]),
      .minw_cfg(minw_cfg), .qual(qual_v[g]), .drop(drop_v[g])
    );
  end

  assign both_on = cmd_hi && cmd_lo;
  assign want_hi = qual_v[0] && !cmd_lo;
  assign want_lo = qual_v[1] && !cmd_hi;

  leg_guard_fsm #(.W(W)) u_fsm (
    .clk(clk), .rst_n(rst_i_n), .want_hi(want_hi), .want_lo(want_lo),
    .dead_cfg(dead_cfg), .state(state)
  );

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      both_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      both_q  <= both_on;
      fault_q <= both_on && !both_q;
    end
  end

  // turn-off is immediate: the live command gates the registered state
  assign gate_hi     = (state == ST_HI) && cmd_hi && !cmd_lo;
  assign gate_lo     = (state == ST_LO) && cmd_lo && !cmd_hi;
  assign fault_both  = fault_q;
  assign drop_narrow = |drop_v;
endmodule

// File: rtl/leg_guard_chk.sv
module leg_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_hi,
  input logic cmd_lo,
  input logic gate_hi,
  input logic gate_lo,
  input logic fault_both
);
  AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo)); // R1
  AST_RISE_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hi) |-> $past(cmd_hi)); // R2
  AST_HI_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_hi |-> !gate_hi); // R3
  AST_LO_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_lo |-> !gate_lo); // R3
  AST_ILLEGAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hi && cmd_lo) |-> (!gate_hi && !gate_lo)); // R4
  AST_FAULT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_both |=> !fault_both); // R4
  AST_SWAP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_lo) |-> !$past(gate_hi)); // R10
endmodule

bind leg_guard leg_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
  .gate_hi(gate_hi), .gate_lo(gate_lo), .fault_both(fault_both)
);

// File: tb/leg_guard_tb.sv
module leg_guard_tb;
  logic       clk;
  logic       rst_n;
  logic       cmd_hi, cmd_lo;
  logic [7:0] dead_cfg, minw_cfg;
  logic       gate_hi, gate_lo, fault_both, drop_narrow;
  int         checks;
  int         errors;
  bit         done;

  leg_guard u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
    .dead_cfg(dead_cfg), .minw_cfg(minw_cfg), .gate_hi(gate_hi),
    .gate_lo(gate_lo), .fault_both(fault_both), .drop_narrow(drop_narrow)
  );

  initial clk = 1'b0;
  always #10 clk = !clk;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    cmd_hi = 1'b0;
    cmd_lo = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // raise one command and walk the turn-on latency edge by edge
  task automatic walk_on(input bit sel_lo, input int m, input int d, input string req);
    for (int k = 1; k <= m + d + 1; k++) begin
      @(negedge clk);
      check(req, sel_lo ? gate_lo : gate_hi, k == m + d + 1);
      check("R1", gate_hi && gate_lo, 1'b0);
    end
  endtask

  initial begin
    rst_n = 1'b0; cmd_hi = 1'b0; cmd_lo = 1'b0; dead_cfg = '0; minw_cfg = '0;
    checks = 0; errors = 0; done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9", gate_hi, 1'b0);
    check("R9", gate_lo, 1'b0);
    check("R9", fault_both, 1'b0);
    check("R9", drop_narrow, 1'b0);

    // R2 / R7 / R10 / R3 / R4 sweep
    for (int m = 0; m < 4; m++) begin
      for (int d = 0; d < 4; d++) begin
        string rq;
        rq = (m == 0 || d == 0) ? "R7" : "R2";
        dead_cfg = 8'(d); minw_cfg = 8'(m);
        idle(4);
        cmd_hi = 1'b1;
        walk_on(1'b0, m, d, rq);
        cmd_hi = 1'b0; cmd_lo = 1'b1;
        #1 check("R3", gate_hi, 1'b0);
        walk_on(1'b1, m, d, "R10");
        cmd_hi = 1'b1;
        #1 check("R4", gate_lo, 1'b0);
        @(negedge clk);
        check("R4", fault_both, 1'b1);
        check("R4", gate_hi || gate_lo, 1'b0);
        @(negedge clk);
        check("R4", fault_both, 1'b0);
        idle(4);
        cmd_lo = 1'b1;
        walk_on(1'b1, m, d, rq);
      end
    end

    // R5 narrow pulses dropped
    for (int m = 2; m < 5; m++) begin
      for (int p = 1; p < m; p++) begin
        dead_cfg = 8'd1; minw_cfg = 8'(m);
        idle(4);
        cmd_hi = 1'b1;
        repeat (p) begin
          @(negedge clk);
          check("R5", gate_hi, 1'b0);
        end
        cmd_hi = 1'b0;
        @(negedge clk);
        check("R5", drop_narrow, 1'b1);
        check("R5", gate_hi, 1'b0);
        @(negedge clk);
        check("R5", drop_narrow, 1'b0);
      end
    end

    // R6 pulses at the limit are kept
    for (int m = 1; m < 4; m++) begin
      dead_cfg = 8'd1; minw_cfg = 8'(m);
      idle(4);
      cmd_lo = 1'b1;
      repeat (m) @(negedge clk);
      cmd_lo = 1'b0;
      @(negedge clk);
      check("R6", drop_narrow, 1'b0);
      @(negedge clk);
      check("R6", drop_narrow, 1'b0);
    end

    // R8 dead-time change during blanking
    dead_cfg = 8'd5; minw_cfg = 8'd0;
    idle(4);
    cmd_hi = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (k == 2) dead_cfg = 8'd1;
      if (k >= 5) check("R8", gate_hi, k == 6);
    end

    // R8 minimum-width change mid-pulse
    dead_cfg = 8'd2; minw_cfg = 8'd3;
    idle(4);
    cmd_lo = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (k == 1) minw_cfg = 8'd0;
      if (k == 3 || k >= 5) check("R8", gate_lo, k == 6);
    end

    // R11 withdrawal during blanking
    dead_cfg = 8'd4; minw_cfg = 8'd0;
    idle(4);
    cmd_hi = 1'b1;
    repeat (2) @(negedge clk);
    cmd_hi = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check("R11", gate_hi, 1'b0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule